// File: doc/BRIEF.md
# Event Pointer List Generator

This block turns per-event completion records into a list of event descriptors that host software reads to find event boundaries in a stream of detector data. Each record gives where an event starts in host memory and how many bytes it holds. The block expands every accepted record into four 32-bit words: a start address, a byte count and two zero words. It pushes them into an internal pointer FIFO that the host drains through a first-word fall-through read port.

The block also counts completed events. It presents a 32-bit status word that combines the pointer FIFO flags with a set of health and mode indications from elsewhere on the board: run and done flags, the external data FIFO flags, loop-back test mode, a data error flag, two deserializer lock signals and a software hold. A record is offered with a valid/ready handshake. While software hold is high, no new descriptor begins.

Top module: `evt_ptr_gen`

## Requirements
- R1: An accepted record produces four FIFO words on four consecutive cycles, starting in the accept cycle. The words are, in order, the address word, the length word (rec_len_i unchanged), 32'h0 and 32'h0. The host reads them in that order.
- R2: The address word is {2'b00, rec_addr_i[29:0]}. Bits 31:30 of rec_addr_i never reach the FIFO.
- R3: rec_ready_o is high only when the sequencer is idle, software hold is low and the FIFO has at least four free entries. A descriptor is therefore never split, and the FIFO never overflows.
- R4: While sw_hold_i is high, no record is accepted. A descriptor that has already started still writes all four words.
- R5: The event count increments by one on the clock edge that writes the fourth word. It saturates at 2^CNT_W-1. status_o[19:0] shows the count, zero-extended.
- R6: status_o bits: 31 = run_i, 30 = done_i, 29 = pointer FIFO full, 28 = pointer FIFO empty, 27 = ext_full_i, 26 = ext_empty_i, 25 = loopback_i, 24 = data_err_i.
- R7: status_o bits: 23 = NOT lock_a_ni, 22 = NOT lock_b_ni, 21 = sw_hold_i, 20 = 0.
- R8: ptr_data_o always shows the oldest unread word, and ptr_empty_o is high when no word is stored. A read pulse removes one word. A read pulse while the FIFO is empty has no effect.
- R9: After reset the FIFO is empty, the event count is zero and the sequencer is idle.
- R10: rec_ready_o stays low for the three cycles after an accept. At most one record is accepted every four cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rec_valid_i | input | 1 | Completion record valid |
| rec_ready_o | output | 1 | Record accepted on this edge when valid is also high |
| rec_addr_i | input | 32 | Event start address in host memory |
| rec_len_i | input | 32 | Event length in bytes |
| sw_hold_i | input | 1 | Software hold; blocks new descriptors |
| ptr_rd_i | input | 1 | Pop one word from the pointer FIFO |
| ptr_data_o | output | 32 | Oldest unread pointer FIFO word |
| ptr_empty_o | output | 1 | Pointer FIFO empty |
| run_i | input | 1 | Run in progress flag |
| done_i | input | 1 | Done flag |
| ext_full_i | input | 1 | External data FIFO full |
| ext_empty_i | input | 1 | External data FIFO empty |
| loopback_i | input | 1 | Loop-back test mode |
| data_err_i | input | 1 | Data error flag |
| lock_a_ni | input | 1 | First deserializer lock, active low |
| lock_b_ni | input | 1 | Second deserializer lock, active low |
| status_o | output | 32 | Aggregated status word |

## Verification
The embedded assertions check four behaviours on every cycle: no write reaches a full FIFO, a read of an empty FIFO leaves its fill level unchanged, software hold keeps the idle sequencer idle, and each fourth word moves the event count by exactly one step or holds it at saturation. Only the bench scenarios can show the rest. These are the content and order of the descriptor words, the stripping of the top address bits, back-pressure when fewer than four entries are free (the FIFO depth is not a multiple of four), a hold that rises mid-descriptor, saturation of the counter, and the bit-exact status layout under changing board inputs. The bench's reference model covers them.

// File: rtl/evt_ptr_pkg.sv
package evt_ptr_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned DESC_WORDS = 4;
  localparam int unsigned ADDR_KEEP  = 30;
  localparam int unsigned STAT_CNT_W = 20;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEN  = 2'd1,
    ST_PAD0 = 2'd2,
    ST_PAD1 = 2'd3
  } desc_state_e;
endpackage

// File: rtl/evt_ptr_fifo.sv
module evt_ptr_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             rd_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [CW-1:0]    count_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    cnt_q;
  logic             do_wr, do_rd;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;
  assign rdata_o = mem_q[rp_q];
  assign do_wr   = wr_i && !full_o;
  assign do_rd   = rd_i && !empty_o;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_wr) wp_q <= ptr_inc(wp_q);
      if (do_rd) rp_q <= ptr_inc(rp_q);
      case ({do_wr, do_rd})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> !full_o); // R3
  AST_EMPTY_READ_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && empty_o && !wr_i) |=> (count_o == '0)); // R8
endmodule

// File: rtl/evt_desc_seq.sv
module evt_desc_seq
  import evt_ptr_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = 20,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rec_valid_i,
  input  logic [WORD_W-1:0] rec_addr_i,
  input  logic [WORD_W-1:0] rec_len_i,
  input  logic              sw_hold_i,
  input  logic [CW-1:0]     fifo_count_i,
  output logic              rec_ready_o,
  output logic              push_o,
  output logic [WORD_W-1:0] push_data_o,
  output logic [CNT_W-1:0]  evt_cnt_o
);
  desc_state_e       state_q, state_d;
  logic [WORD_W-1:0] len_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              room, accept;

  assign room        = (int'(fifo_count_i) + int'(DESC_WORDS)) <= int'(DEPTH);
  assign rec_ready_o = (state_q == ST_IDLE) && !sw_hold_i && room;
  assign accept      = rec_valid_i && rec_ready_o;
  assign push_o      = accept || (state_q != ST_IDLE);
  assign evt_cnt_o   = cnt_q;

  always_comb begin
    unique case (state_q)
      ST_IDLE: push_data_o = {{(WORD_W-ADDR_KEEP){1'b0}}, rec_addr_i[ADDR_KEEP-1:0]};
      ST_LEN:  push_data_o = len_q;
      default: push_data_o = '0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_LEN;
      ST_LEN:  state_d = ST_PAD0;
      ST_PAD0: state_d = ST_PAD1;
      ST_PAD1: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) len_q <= rec_len_i;
      if (state_q == ST_PAD1 && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_HOLD_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_hold_i && state_q == ST_IDLE) |=> (state_q == ST_IDLE)); // R4
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PAD1 && cnt_q != '1) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R5
  AST_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PAD1 && cnt_q == '1) |=> (cnt_q == '1)); // R5
  AST_BUSY_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !rec_ready_o); // R10
endmodule

// File: rtl/evt_status_pack.sv
module evt_status_pack
  import evt_ptr_pkg::*;
#(
  parameter int unsigned CNT_W = 20
) (
  input  logic              run_i,
  input  logic              done_i,
  input  logic              pf_full_i,
  input  logic              pf_empty_i,
  input  logic              ext_full_i,
  input  logic              ext_empty_i,
  input  logic              loopback_i,
  input  logic              data_err_i,
  input  logic              lock_a_ni,
  input  logic              lock_b_ni,
  input  logic              sw_hold_i,
  input  logic [CNT_W-1:0]  evt_cnt_i,
  output logic [WORD_W-1:0] status_o
);
  logic [STAT_CNT_W-1:0] cnt_field;

  generate
    if (CNT_W >= STAT_CNT_W) begin : g_trunc
      assign cnt_field = evt_cnt_i[STAT_CNT_W-1:0];
    end else begin : g_ext
      assign cnt_field = {{(STAT_CNT_W-CNT_W){1'b0}}, evt_cnt_i};
    end
  endgenerate

  assign status_o = {run_i, done_i, pf_full_i, pf_empty_i,
                     ext_full_i, ext_empty_i, loopback_i, data_err_i,
                     ~lock_a_ni, ~lock_b_ni, sw_hold_i, 1'b0,
                     cnt_field};
endmodule

// File: rtl/evt_ptr_gen.sv
module evt_ptr_gen
  import evt_ptr_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = 20,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rec_valid_i,
  output logic        rec_ready_o,
  input  logic [31:0] rec_addr_i,
  input  logic [31:0] rec_len_i,
  input  logic        sw_hold_i,
  input  logic        ptr_rd_i,
  output logic [31:0] ptr_data_o,
  output logic        ptr_empty_o,
  input  logic        run_i,
  input  logic        done_i,
  input  logic        ext_full_i,
  input  logic        ext_empty_i,
  input  logic        loopback_i,
  input  logic        data_err_i,
  input  logic        lock_a_ni,
  input  logic        lock_b_ni,
  output logic [31:0] status_o
);
  logic              push;
  logic [WORD_W-1:0] push_data;
  logic              pf_full, pf_empty;
  logic [CW-1:0]     pf_count;
  logic [CNT_W-1:0]  evt_cnt;

  evt_desc_seq #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rec_valid_i  (rec_valid_i),
    .rec_addr_i   (rec_addr_i),
    .rec_len_i    (rec_len_i),
    .sw_hold_i    (sw_hold_i),
    .fifo_count_i (pf_count),
    .rec_ready_o  (rec_ready_o),
    .push_o       (push),
    .push_data_o  (push_data),
    .evt_cnt_o    (evt_cnt)
  );

  evt_ptr_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (push),
    .wdata_i (push_data),
    .rd_i    (ptr_rd_i),
    .rdata_o (ptr_data_o),
    .full_o  (pf_full),
    .empty_o (pf_empty),
    .count_o (pf_count)
  );

  evt_status_pack #(.CNT_W(CNT_W)) u_stat (
    .run_i       (run_i),
    .done_i      (done_i),
    .pf_full_i   (pf_full),
    .pf_empty_i  (pf_empty),
    .ext_full_i  (ext_full_i),
    .ext_empty_i (ext_empty_i),
    .loopback_i  (loopback_i),
    .data_err_i  (data_err_i),
    .lock_a_ni   (lock_a_ni),
    .lock_b_ni   (lock_b_ni),
    .sw_hold_i   (sw_hold_i),
    .evt_cnt_i   (evt_cnt),
    .status_o    (status_o)
  );

  assign ptr_empty_o = pf_empty;

  AST_ROOM_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_i && rec_ready_o) |-> (int'(pf_count) + 4 <= int'(DEPTH))); // R3
endmodule

// File: tb/tb_evt_ptr_gen.sv
module tb_evt_ptr_gen;
  localparam int DEPTH = 10;
  localparam int CNT_W = 3;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic clk = 0, rst_n = 0;
  logic valid = 0, hold = 0, rd = 0;
  logic [31:0] addr = 0, len = 0;
  logic run = 0, done = 0, ef = 0, ee = 0, lb = 0, derr = 0, la_n = 1, lb_n = 1;
  logic rdy, empty;
  logic [31:0] pdata, status;

  always #5 clk = ~clk;

  evt_ptr_gen #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .rec_valid_i(valid), .rec_ready_o(rdy),
    .rec_addr_i(addr), .rec_len_i(len), .sw_hold_i(hold), .ptr_rd_i(rd),
    .ptr_data_o(pdata), .ptr_empty_o(empty), .run_i(run), .done_i(done),
    .ext_full_i(ef), .ext_empty_i(ee), .loopback_i(lb), .data_err_i(derr),
    .lock_a_ni(la_n), .lock_b_ni(lb_n), .status_o(status));

  int checks = 0, errors = 0;
  logic [31:0] q[$];
  bit          qa[$];
  int          st = 0, cnt_m = 0;
  logic [31:0] len_m = 0;
  bit          acc_evt = 0;
  int          rd_mode = 0, phase = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit model_rdy();
    return (st == 0) && !hold && (DEPTH - q.size() >= 4);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); qa.delete(); st = 0; cnt_m = 0; acc_evt = 0;
    end else begin
      bit r; int pre;
      pre = q.size(); r = model_rdy(); acc_evt = 0;
      if (rd && pre > 0) begin void'(q.pop_front()); void'(qa.pop_front()); end
      case (st)
        0: if (valid && r) begin
             q.push_back({2'b00, addr[29:0]}); qa.push_back(1);
             len_m = len; st = 1; acc_evt = 1;
           end
        1: begin q.push_back(len_m); qa.push_back(0); st = 2; end
        2: begin q.push_back(32'h0); qa.push_back(0); st = 3; end
        default: begin
          q.push_back(32'h0); qa.push_back(0); st = 0;
          if (cnt_m < MAXC) cnt_m++;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    phase++;
    case (rd_mode)
      0: rd = 0;
      1: rd = 1;
      default: rd = phase[0];
    endcase
  end

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      logic [31:0] es;
      string rtag;
      rtag = (st != 0) ? "R10" : (hold ? "R4" : "R3");
      chk(rdy == model_rdy(), rtag, 32'(rdy), 32'(model_rdy()));
      chk(empty == (q.size() == 0), "R8", 32'(empty), 32'(q.size() == 0));
      if (q.size() > 0)
        chk(pdata == q[0], qa[0] ? "R2" : "R1", pdata, q[0]);
      es = {run, done, q.size() == DEPTH, q.size() == 0, ef, ee, lb, derr,
            ~la_n, ~lb_n, hold, 1'b0, 20'(cnt_m)};
      chk(status[31:24] == es[31:24], "R6", status, es);
      chk(status[23:20] == es[23:20], "R7", status, es);
      chk(status[19:0]  == es[19:0],  "R5", status, es);
    end
  end

  task automatic send(input logic [31:0] a, input logic [31:0] l);
    @(negedge clk); valid = 1; addr = a; len = l;
    do begin @(posedge clk); #1; end while (!acc_evt);
    @(negedge clk); valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int seen;
    #1000000;
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1;
    @(negedge clk); #2;
    chk(empty == 1, "R9", 32'(empty), 1);
    chk(status[19:0] == 0, "R9", status, 0);
    chk(rdy == 1, "R9", 32'(rdy), 1);

    // draining continuously, top address bits set
    rd_mode = 1;
    send(32'hC000_1000, 32'd64);
    send(32'hFFFF_FFFC, 32'd4096);
    send(32'h4000_0010, 32'd1);
    idle(8);

    // no draining: third record must wait for room
    rd_mode = 0;
    send(32'h0000_0100, 32'd12);
    send(32'h0000_0200, 32'd24);
    @(negedge clk); valid = 1; addr = 32'h8000_0300; len = 32'd36;
    begin
      int seen = 0;
      repeat (6) begin @(posedge clk); #1; if (acc_evt) seen++; end
      chk(seen == 0, "R3", 32'(seen), 0);
    end
    rd_mode = 1;
    do begin @(posedge clk); #1; end while (!acc_evt);
    @(negedge clk); valid = 0;
    idle(10);

    // hold rising mid-descriptor, then held off
    rd_mode = 2;
    @(negedge clk); valid = 1; addr = 32'h0000_0A00; len = 32'd100;
    do begin @(posedge clk); #1; end while (!acc_evt);
    @(negedge clk); hold = 1; addr = 32'h0000_0B00; len = 32'd200;
    begin
      int seen = 0;
      repeat (8) begin @(posedge clk); #1; if (acc_evt) seen++; end
      chk(seen == 0, "R4", 32'(seen), 0);
    end
    @(negedge clk); hold = 0;
    do begin @(posedge clk); #1; end while (!acc_evt);
    @(negedge clk); valid = 0;
    idle(10);

    // empty read has no effect, status sweep
    rd_mode = 1;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      {run, done, ef, ee, lb, derr, la_n, lb_n} = 8'(i * 37);
    end
    chk(empty == 1, "R8", 32'(empty), 1);

    // saturation
    rd_mode = 2;
    for (int i = 0; i < 6; i++) send(32'h1000 * i, 32'(i + 5));
    idle(12);
    chk(status[19:0] == MAXC, "R5", status, MAXC);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule